// File: doc/BRIEF.md
# RAM-Based Histogram Counter

This block accumulates a histogram of 8-bit samples. Every accepted sample names one of 256 bins, and the 16-bit count stored for that bin in a synchronous RAM goes up by one. The update is a two-step pipeline. In the first step the RAM is read at the sample's address. In the second step the count is incremented and written back.

A one-entry forwarding register holds the most recent write. A sample that hits the bin still being written is therefore counted from the fresh value, and identical samples can arrive on every clock without stalls.

A sweep clears the RAM one address per cycle. It runs automatically after reset and again on request, and samples are refused while it runs. When capture is switched off, a host reads any bin through a read port with one cycle of latency.

Top module: `histogram_rmw`

## Requirements
- R1: After reset release, `busy` is high for 256 cycles (the cycle of release included), and afterwards every bin reads zero.
- R2: A sample is accepted on a rising edge when `smp_valid`=1, `capture_en`=1, `busy`=0 and `clear_req`=0. Accepting it adds one to the bin whose address equals `smp_value`.
- R3: The new count is written on the rising edge after acceptance. A host read whose address is sampled on the second rising edge after acceptance, or on any later edge, returns the new count.
- R4: Identical samples accepted on consecutive cycles are all counted, including runs of any length and alternations between two bins.
- R5: Samples to different bins, in any order, update only their own bins.
- R6: A count that has reached 65535 stays at 65535 on further hits and never wraps.
- R7: A `clear_req` pulse while idle raises `busy` on the next edge. The sweep then writes zero to addresses 0, 1, …, 255, one per cycle, and `busy` stays high for exactly 256 cycles.
- R8: A sample presented while `busy`=1, while `clear_req`=1, or while `capture_en`=0 does not change any count.
- R9: While `capture_en`=0, `rd_data` shows the count of the bin whose address was on `rd_addr` at the previous rising edge. A new address may be given on every cycle.
- R10: Cycles with `smp_valid`=0 change no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts a clear sweep |
| clear_req | input | 1 | One-cycle request to zero all bins |
| capture_en | input | 1 | 1: samples are accepted; 0: host read port owns the RAM read |
| smp_valid | input | 1 | Sample strobe |
| smp_value | input | 8 | Sample value, which is also the bin address |
| rd_addr | input | 8 | Host read bin address |
| rd_data | output | 16 | Count of the bin addressed on the previous edge |
| busy | output | 1 | Clear sweep in progress |

## Verification
The assertions assume that `clear_req` is only pulsed while `busy` is low. They also assume that the host read port is used only after capture has been off for at least two edges, so that no update is still in flight. The bench stays within both limits. It issues each clear from the idle state, and it drops `capture_en` and inserts idle cycles before any host read. The only exception is the dedicated R3 check, which reads at exactly the earliest legal edge. All sample values are generated inside the 8-bit range.

// File: rtl/hist_pkg.sv
package hist_pkg;

    // Which agent owns the RAM write port in a given cycle
    typedef enum logic [1:0] {
        WSRC_IDLE   = 2'd0,
        WSRC_UPDATE = 2'd1,
        WSRC_SWEEP  = 2'd2
    } wsrc_e;

    // Which agent owns the RAM read address
    typedef enum logic {
        RSRC_SAMPLE = 1'b0,
        RSRC_HOST   = 1'b1
    } rsrc_e;

endpackage

// File: rtl/hist_ram.sv
// Synchronous RAM, one write and one read port; a read returns the
// contents before a same-edge write (read-old behaviour).
module hist_ram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/hist_sweep.sv
// Clear sequencer: walks every address once, writing zero.
module hist_sweep #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr
);
    localparam logic [AW-1:0] LAST = '1;

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] ptr;
    } sweep_t;

    sweep_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            s_d.ptr = s_q.ptr + 1'b1;
            if (s_q.ptr == LAST) begin
                s_d.busy = 1'b0;
            end
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.ptr  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.busy <= 1'b1;   // clear runs straight out of reset
            s_q.ptr  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign wr_en   = s_q.busy;
    assign wr_addr = s_q.ptr;
endmodule

// File: rtl/hist_update.sv
// Read-increment-write pipeline with single-entry write forwarding.
// Step 1: RAM read issued at acceptance (outside this module).
// Step 2: pick base (RAM data or forwarded write), saturating +1, write.
module hist_update #(
    parameter int unsigned AW = 8,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] accept_addr,
    input  logic [CW-1:0] ram_rdata,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [CW-1:0] wr_data
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic          rd_vld;   // item whose RAM read is returning
        logic [AW-1:0] rd_addr;
        logic          fw_vld;   // write performed on the previous edge
        logic [AW-1:0] fw_addr;
        logic [CW-1:0] fw_data;
    } upd_t;

    upd_t u_d, u_q;
    logic          hit;
    logic [CW-1:0] base;
    logic [CW-1:0] next_cnt;

    always_comb begin
        hit      = u_q.fw_vld && (u_q.fw_addr == u_q.rd_addr);
        base     = hit ? u_q.fw_data : ram_rdata;
        next_cnt = (base == CNT_MAX) ? base : base + 1'b1;

        u_d         = u_q;
        u_d.rd_vld  = accept;
        u_d.rd_addr = accept_addr;
        u_d.fw_vld  = u_q.rd_vld;
        u_d.fw_addr = u_q.rd_addr;
        u_d.fw_data = next_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_q <= '0;
        end else begin
            u_q <= u_d;
        end
    end

    assign wr_en   = u_q.rd_vld;
    assign wr_addr = u_q.rd_addr;
    assign wr_data = next_cnt;
endmodule

// File: rtl/histogram_rmw.sv
module histogram_rmw
    import hist_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_req,
    input  logic          capture_en,
    input  logic          smp_valid,
    input  logic [AW-1:0] smp_value,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data,
    output logic          busy
);
    logic          swp_busy;
    logic          swp_we;
    logic [AW-1:0] swp_addr;
    logic          accept;
    logic          upd_we;
    logic [AW-1:0] upd_addr;
    logic [CW-1:0] upd_wdata;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [CW-1:0] ram_wdata;
    logic [AW-1:0] ram_raddr;
    logic [CW-1:0] ram_rdata;
    wsrc_e         wsrc;
    rsrc_e         rsrc;

    // Samples are refused during a sweep and on the cycle a sweep is requested
    assign accept = smp_valid && capture_en && !swp_busy && !clear_req;

    hist_sweep #(.AW(AW)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (clear_req),
        .busy    (swp_busy),
        .wr_en   (swp_we),
        .wr_addr (swp_addr)
    );

    hist_update #(.AW(AW), .CW(CW)) u_update (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .accept_addr (smp_value),
        .ram_rdata   (ram_rdata),
        .wr_en       (upd_we),
        .wr_addr     (upd_addr),
        .wr_data     (upd_wdata)
    );

    always_comb begin
        if (swp_we) begin
            wsrc = WSRC_SWEEP;
        end else if (upd_we) begin
            wsrc = WSRC_UPDATE;
        end else begin
            wsrc = WSRC_IDLE;
        end

        ram_we    = (wsrc != WSRC_IDLE);
        ram_waddr = (wsrc == WSRC_SWEEP) ? swp_addr : upd_addr;
        ram_wdata = (wsrc == WSRC_SWEEP) ? '0 : upd_wdata;

        rsrc      = capture_en ? RSRC_SAMPLE : RSRC_HOST;
        ram_raddr = (rsrc == RSRC_HOST) ? rd_addr : smp_value;
    end

    hist_ram #(.AW(AW), .DW(CW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    assign rd_data = ram_rdata;
    assign busy    = swp_busy;
endmodule

// File: rtl/hist_checker.sv
module hist_checker #(
    parameter int unsigned AW = 8,
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          clear_req,
    input logic          accept,
    input logic          upd_we,
    input logic [CW-1:0] upd_wdata,
    input logic          swp_we,
    input logic [AW-1:0] swp_addr,
    input logic [CW-1:0] ram_wdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [AW:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    // R7: a sweep spans exactly one write per address
    assert_sweep_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == (AW+1)'(DEPTH)));

    // R7: a clear request while idle starts the sweep on the next edge
    assert_clear_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !busy) |=> busy);

    // R7: sweep writes zeros
    assert_sweep_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        swp_we |-> (ram_wdata == '0));

    // R7: sweep addresses ascend by one
    assert_sweep_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (swp_we && $past(swp_we) && $past(rst_n)) |-> (swp_addr == AW'($past(swp_addr) + 1'b1)));

    // R8: nothing accepted while the sweep runs
    assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);

    // R8: sweep and update never compete for the write port
    assert_no_write_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_we && swp_we));

    // R3: an accepted sample is written on the following edge
    assert_write_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> upd_we);

    // R6: a saturating increment never produces zero
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_we |-> (upd_wdata != '0));
endmodule

bind histogram_rmw hist_checker #(.AW(AW), .CW(CW)) u_hist_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .clear_req (clear_req),
    .accept    (accept),
    .upd_we    (upd_we),
    .upd_wdata (upd_wdata),
    .swp_we    (swp_we),
    .swp_addr  (swp_addr),
    .ram_wdata (ram_wdata)
);

// File: tb/test_histogram_rmw.sv
module test_histogram_rmw;
    localparam int AW = 8;
    localparam int CW = 16;
    localparam int NBIN = 1 << AW;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_req = 1'b0;
    logic          capture_en = 1'b0;
    logic          smp_valid = 1'b0;
    logic [AW-1:0] smp_value = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic          busy;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int model [NBIN];

    typedef struct {
        int    addr;
        int    exp;
        string req;
        int    cyc;
    } sb_item_t;
    sb_item_t sb [$];

    always #10 clk = ~clk;   // 50 MHz

    histogram_rmw #(.AW(AW), .CW(CW)) i_histogram_rmw (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_req  (clear_req),
        .capture_en (capture_en),
        .smp_valid  (smp_valid),
        .smp_value  (smp_value),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compares host reads one edge after their address was driven
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #5;
            while (sb.size() > 0 && sb[0].cyc < cyc) begin
                checks++;
                if (int'(rd_data) != sb[0].exp) begin
                    errors++;
                    $display("FAIL %s: bin %0d actual=%0d expected=%0d",
                             sb[0].req, sb[0].addr, rd_data, sb[0].exp);
                end
                void'(sb.pop_front());
            end
        end
    end

    task automatic rd(input int a, input int exp, input string req);
        sb_item_t it;
        @(negedge clk);
        rd_addr = a[AW-1:0];
        it.addr = a; it.exp = exp; it.req = req; it.cyc = cyc;
        sb.push_back(it);
    endtask

    task automatic send(input int v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_value = v[AW-1:0];
        if (model[v] < CMAX) model[v]++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b0;
        end
    endtask

    task automatic pause();
        @(negedge clk);
        smp_valid  = 1'b0;
        capture_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic resume();
        @(negedge clk);
        capture_en = 1'b1;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_all_zero(input string req);
        for (int i = 0; i < NBIN; i++) rd(i, 0, req);
    endtask

    initial begin
        int n;
        for (int i = 0; i < NBIN; i++) model[i] = 0;

        // R1: reset state and automatic sweep
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
        rst_n = 1'b1;
        count_busy(n);
        check(n == 256, "R1 sweep length after reset", n, 256);
        read_all_zero("R1/R9");

        // R3: earliest legal read after a single sample
        resume();
        send(77);
        @(negedge clk);
        smp_valid  = 1'b0;
        capture_en = 1'b0;
        rd(77, model[77], "R3");

        // R2, R5, R10: separated distinct samples with valid-low gaps
        resume();
        send(0);   idle(1);
        send(255); idle(2);
        send(3);   idle(1);
        send(10);
        send(3);
        pause();
        rd(0, model[0], "R2");
        rd(255, model[255], "R2");
        rd(3, model[3], "R5");
        rd(10, model[10], "R5");
        rd(4, 0, "R10");
        rd(77, model[77], "R5");

        // R4: back-to-back identical and alternating samples
        resume();
        for (int i = 0; i < 20; i++) send(42);
        for (int i = 0; i < 10; i++) begin send(42); send(43); end
        send(42); send(42); send(43); send(42);
        pause();
        rd(42, model[42], "R4");
        rd(43, model[43], "R4");
        rd(41, 0, "R4");

        // R8: samples with capture disabled are ignored
        @(negedge clk);
        smp_valid = 1'b1;
        smp_value = 8'd42;
        repeat (5) @(negedge clk);
        smp_valid = 1'b0;
        rd(42, model[42], "R8 capture off");

        // R7 + R8: clear sweep, samples during request and sweep ignored
        @(negedge clk);
        capture_en = 1'b1;
        smp_valid  = 1'b1;
        smp_value  = 8'd5;
        clear_req  = 1'b1;
        for (int i = 0; i < NBIN; i++) model[i] = 0;
        @(negedge clk);
        clear_req = 1'b0;
        count_busy(n);
        check(n == 256, "R7 sweep length", n, 256);
        smp_valid = 1'b0;
        pause();
        read_all_zero("R7/R8");

        // R6: saturation (also a long R4 run)
        resume();
        for (int i = 0; i < CMAX + 5; i++) send(7);
        pause();
        rd(7, CMAX, "R6");
        rd(8, 0, "R6 neighbour");
        rd(6, 0, "R6 neighbour");

        // R9: back-to-back host reads of varied addresses
        for (int i = 0; i < 16; i++) rd(7 - (i % 3), model[7 - (i % 3)], "R9");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule